// File: doc/BRIEF.md
# Triangle-Wave PWM Timer Channel with Double-Buffered Compare

This block is one 16-bit timer channel that counts in a triangle. After a preset it starts at zero, counts up to a programmable ceiling, then counts back down to zero, and repeats. It advances by one step on each clock where the run bit is set and the external clock enable is high. The channel raises three sticky event flags: the ceiling was reached, zero was reached, and the counter matched the compare value. Software clears a flag by writing a one to its bit. The compare output is a level that is high whenever the counter is at or above the active compare value, which gives a centre-aligned PWM waveform.

Software writes the compare value into a shadow register. A 3-bit transfer mode decides when the shadow value is copied into the comparator that is actually in use: at once, at zero, at the ceiling, at both, or only at a zero reached while counting down. Moving the copy to a turning point lets software change the duty cycle without producing a glitch partway through a period.

All configuration goes through a single write port made of an enable, a 2-bit register select and a data word. It has no handshake, and a write completes on the clock edge where the enable is high. The clock enable, the flag-clear mask and all outputs are plain level signals.

Top module: `updown_pwm_timer`

## Requirements
- R1: When a write selects register 0, the ceiling takes the written value. While counting, the counter moves 0,1,…,ceiling,ceiling-1,…,1,0,1,… and turns once at each end. It starts counting up after a preset.
- R2: `flags[0]` is set after any enabled cycle that begins with the counter counting up and at or above the ceiling. `flags[1]` is set after any enabled cycle that begins with the counter at zero.
- R3: `flags[2]` is set after any enabled cycle that begins with the counter equal to the active compare value. This happens when counting up and when counting down.
- R4: A cycle is enabled only when the run bit is 1 and `cnt_en` is high. In any other cycle the counter and the flags hold their values.
- R5: A write to register 3 loads bit 0 into the run bit. If bit 1 is 1, the same write forces the counter to 0 and the direction to up, whatever the run state.
- R6: Each 1 in `flag_clr` clears its flag. If the hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R7: A write to register 1 always loads the shadow compare register. A write to register 2 loads the mode from data bits 2:0. In mode 0, and in the unused codes 5, 6 and 7, a write to register 1 also loads the active compare value in the same edge.
- R8: In mode 1 the shadow value is copied to the active compare value on each enabled cycle that begins with the counter at zero.
- R9: In mode 2 the copy happens on each enabled cycle that begins at the ceiling. In mode 3 it happens at both zero and the ceiling.
- R10: In mode 4 the copy happens only on an enabled cycle that begins at zero while the counter is counting down. A zero reached just after a preset, while counting up, does not copy.
- R11: `cmp_out` is high exactly when the counter is greater than or equal to the active compare value.
- R12: With a ceiling of 0, each enabled cycle leaves the counter at 0 and sets both `flags[0]` and `flags[1]`.
- R13: After reset the counter is 0 and counting up. The run bit is 0, the flags are 0, the ceiling is all ones, the mode is 0, and the shadow and active compare values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 ceiling, 1 compare shadow, 2 mode, 3 control |
| wr_data | input | 16 | Write data |
| cnt_en | input | 1 | Count clock enable |
| flag_clr | input | 3 | Write-one-to-clear mask for the flags |
| flags | output | 3 | Sticky flags: [0] ceiling, [1] zero, [2] compare match |
| cmp_out | output | 1 | PWM level: counter ≥ active compare |
| count | output | 16 | Current counter value |

## Verification
Assertions placed inside the RTL check on every cycle the following: the counter steps up by one when it should, it holds when a cycle is not enabled, a preset returns it to zero counting up, a zero ceiling pins it at zero, set wins over clear in the flags, and a direct-mode write reaches the comparator on the next edge. Only the bench scenarios can show when a buffered value takes effect. To do that, they watch `cmp_out` at counter values where the old and new compare values give opposite answers, before and after each turning point, for every mode. Those scenarios also show the full triangle sequence and the compare flag firing on both slopes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned NFLAGS = 3;
  localparam int unsigned FLAG_PEAK = 0;
  localparam int unsigned FLAG_ZERO = 1;
  localparam int unsigned FLAG_CMP  = 2;

  localparam logic [1:0] SEL_CEIL = 2'd0;
  localparam logic [1:0] SEL_CMP  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  localparam logic [2:0] XFER_DIRECT    = 3'd0;
  localparam logic [2:0] XFER_ZERO      = 3'd1;
  localparam logic [2:0] XFER_PEAK      = 3'd2;
  localparam logic [2:0] XFER_BOTH      = 3'd3;
  localparam logic [2:0] XFER_ZERO_DOWN = 3'd4;
endpackage

// File: rtl/tri_counter.sv
module tri_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         preset,
  input  logic [W-1:0] ceil_val,
  output logic [W-1:0] cnt,
  output logic         going_down,
  output logic         peak_ev,
  output logic         zero_ev
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  assign peak_ev = tick && !going_down && (cnt >= ceil_val);
  assign zero_ev = tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      going_down <= 1'b0;
    end else if (preset) begin
      cnt        <= '0;
      going_down <= 1'b0;
    end else if (tick) begin
      if (ceil_val == '0) begin
        cnt        <= '0;
        going_down <= 1'b0;
      end else if (!going_down) begin
        if (cnt >= ceil_val) begin
          going_down <= 1'b1;
          cnt        <= cnt - ONE;
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (cnt == '0) begin
        going_down <= 1'b0;
        cnt        <= ONE;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assert_step_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !preset && !going_down && ceil_val != '0 && cnt < ceil_val)
      |=> cnt == $past(cnt) + ONE);

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !preset) |=> $stable(cnt));

  assert_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (cnt == '0 && !going_down));

  assert_zero_ceiling_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !preset && ceil_val == '0) |=> cnt == '0);
endmodule

// File: rtl/cmp_shadow.sv
module cmp_shadow #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic [2:0]   mode,
  input  logic         zero_ev,
  input  logic         peak_ev,
  input  logic         going_down,
  output logic [W-1:0] active
);
  import pwm_pkg::*;

  logic [W-1:0] shadow;
  logic         direct;
  logic         xfer;

  always_comb begin
    direct = 1'b0;
    xfer   = 1'b0;
    case (mode)
      XFER_ZERO:      xfer = zero_ev;
      XFER_PEAK:      xfer = peak_ev;
      XFER_BOTH:      xfer = zero_ev || peak_ev;
      XFER_ZERO_DOWN: xfer = zero_ev && going_down;
      default:        direct = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (wr) shadow <= wr_val;
      if (direct && wr)  active <= wr_val;
      else if (xfer)     active <= shadow;
    end
  end

  assert_direct_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (mode == XFER_DIRECT || mode > XFER_ZERO_DOWN)) |=> active == $past(wr_val));

  assert_no_idle_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !zero_ev && !peak_ev) |=> $stable(active));
endmodule

// File: rtl/evt_flags.sv
module evt_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((flags & $past(set)) == $past(set)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set == '0) |=> ((flags & $past(clr)) == '0));
endmodule

// File: rtl/updown_pwm_timer.sv
module updown_pwm_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         cnt_en,
  input  logic [2:0]   flag_clr,
  output logic [2:0]   flags,
  output logic         cmp_out,
  output logic [W-1:0] count
);
  import pwm_pkg::*;

  logic [W-1:0] ceil_q;
  logic [2:0]   mode_q;
  logic         run_q;
  logic         tick, preset, going_down, peak_ev, zero_ev;
  logic [W-1:0] active;
  logic [NFLAGS-1:0] set_vec;

  assign tick   = run_q && cnt_en;
  assign preset = wr_en && (wr_sel == SEL_CTRL) && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_q <= '1;
      mode_q <= XFER_DIRECT;
      run_q  <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CEIL: ceil_q <= wr_data;
        SEL_MODE: mode_q <= wr_data[2:0];
        SEL_CTRL: run_q  <= wr_data[0];
        default:  ;
      endcase
    end
  end

  tri_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .preset(preset), .ceil_val(ceil_q),
    .cnt(count), .going_down(going_down), .peak_ev(peak_ev), .zero_ev(zero_ev)
  );

  cmp_shadow #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_sel == SEL_CMP), .wr_val(wr_data),
    .mode(mode_q), .zero_ev(zero_ev), .peak_ev(peak_ev), .going_down(going_down),
    .active(active)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_PEAK] = peak_ev;
    set_vec[FLAG_ZERO] = zero_ev;
    set_vec[FLAG_CMP]  = tick && (count == active);
  end

  evt_flags #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(flag_clr), .flags(flags)
  );

  assign cmp_out = (count >= active);

  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && flag_clr == '0) |=> $stable(flags));
endmodule

// File: tb/tb_updown_pwm_timer.sv
module tb_updown_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        cnt_en = 1'b0;
  logic [2:0]  flag_clr = 3'd0;
  logic [2:0]  flags;
  logic        cmp_out;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  updown_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_en(cnt_en), .flag_clr(flag_clr), .flags(flags), .cmp_out(cmp_out), .count(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111;
    @(posedge clk); @(negedge clk);
    flag_clr = 3'b000;
  endtask

  task automatic t_reset();
    chk("R13 count", count, 0);
    chk("R13 flags", flags, 0);
    chk("R13 cmp_out", cmp_out, 1);
  endtask

  task automatic t_triangle();
    int exp_seq[9] = '{1, 2, 3, 4, 3, 2, 1, 0, 1};
    wr(2'd0, 16'd4);
    wr(2'd3, 16'd3);
    chk("R5 preset count", count, 0);
    for (int k = 0; k < 9; k++) begin
      step(1);
      chk("R1 sequence", count, exp_seq[k]);
      if (k == 0) chk("R2 zero flag", flags[1], 1);
      if (k == 3) chk("R2 peak flag not yet", flags[0], 0);
      if (k == 4) chk("R2 peak flag", flags[0], 1);
    end
    clear_flags();
    chk("R6 cleared", flags, 0);
  endtask

  task automatic t_zero_ceiling();
    wr(2'd0, 16'd0);
    step(2);
    chk("R12 held at zero", count, 0);
    chk("R12 both flags", flags[1:0], 3);
    cnt_en = 1'b1; flag_clr = 3'b011;
    @(posedge clk); @(negedge clk);
    cnt_en = 1'b0; flag_clr = 3'b000;
    chk("R6 set wins", flags[1:0], 3);
    clear_flags();
    chk("R6 clear", flags, 0);
  endtask

  task automatic t_direct();
    wr(2'd0, 16'd6);
    wr(2'd3, 16'd3);
    step(2);
    chk("R1 count 2", count, 2);
    wr(2'd1, 16'd3);
    chk("R7 direct 3", cmp_out, 0);
    wr(2'd1, 16'd2);
    chk("R11 equal high", cmp_out, 1);
    wr(2'd2, 16'd6);
    wr(2'd1, 16'd3);
    chk("R7 code 6 direct", cmp_out, 0);
  endtask

  task automatic t_mode_zero();
    wr(2'd2, 16'd1);
    wr(2'd1, 16'd1);
    chk("R8 no early load", cmp_out, 0);
    step(8);
    chk("R1 count down 2", count, 2);
    chk("R8 still old", cmp_out, 0);
    step(2);
    chk("R1 count 0", count, 0);
    step(1);
    chk("R8 loaded at zero", cmp_out, 1);
  endtask

  task automatic t_mode_peak();
    wr(2'd2, 16'd2);
    wr(2'd1, 16'd5);
    step(1);
    chk("R9 before peak", cmp_out, 1);
    step(6);
    chk("R1 count 4", count, 4);
    chk("R9 loaded at peak", cmp_out, 0);
  endtask

  task automatic t_mode_zero_down();
    wr(2'd2, 16'd4);
    wr(2'd3, 16'd3);
    wr(2'd1, 16'd2);
    step(2);
    chk("R10 count 2", count, 2);
    chk("R10 no load on rising zero", cmp_out, 0);
    step(10);
    chk("R10 count 0", count, 0);
    step(2);
    chk("R10 loaded on falling zero", cmp_out, 1);
  endtask

  task automatic t_mode_both();
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd4);
    step(4);
    chk("R9 count 6", count, 6);
    step(3);
    chk("R9 both at peak", cmp_out, 0);
    wr(2'd1, 16'd1);
    step(4);
    chk("R9 count 1", count, 1);
    chk("R9 both at zero", cmp_out, 1);
  endtask

  task automatic t_cmp_flag();
    wr(2'd2, 16'd0);
    wr(2'd1, 16'd3);
    clear_flags();
    step(2);
    chk("R3 no match yet", flags[2], 0);
    step(1);
    chk("R3 match rising", flags[2], 1);
    clear_flags();
    step(5);
    chk("R3 count 3 falling", count, 3);
    chk("R3 no match yet", flags[2], 0);
    step(1);
    chk("R3 match falling", flags[2], 1);
  endtask

  task automatic t_run_gate();
    clear_flags();
    wr(2'd3, 16'd0);
    step(3);
    chk("R4 stopped count", count, 2);
    chk("R4 stopped flags", flags, 0);
    wr(2'd3, 16'd2);
    chk("R5 preset while stopped", count, 0);
    step(2);
    chk("R4 still stopped", count, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_triangle();
    t_zero_ceiling();
    t_direct();
    t_mode_zero();
    t_mode_peak();
    t_mode_zero_down();
    t_mode_both();
    t_cmp_flag();
    t_run_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule